// File: doc/BRIEF.md
# Mesh Routing Switchpoint with First-Arrival Backtrace

This block is one diamond switchpoint of a mesh routing fabric used to route nets with hardware assistance. It has four sides (north, east, south, west) and six pairwise connections between them. During a search pass, a one that arrives on any side is passed on to the other three sides. A connection that is free passes the one on at once. A connection that another net already holds passes it on only after a programmable number of extra cycles, or never when the no-congestion mode is on. A connection already given to the net being routed counts as free. The switchpoint records the side on which the wavefront reached it first. A random value supplied from outside picks one side when several sides arrive in the same cycle.

In the allocate pass, the sink side sends a one back. Each switchpoint it reaches steers that one out of its recorded side and marks the connection it used as part of the current net. The connections traced this way form the least-delay path. If a connection taken this way was already held by another net, it is also marked as a victim. A later victim pass propagates only along victim connections, so the displaced net can be found and ripped up. A search pass that is started without clearing the recorded side keeps the earlier preferences. This is the fallback pass: paths already recorded win ties against new paths of equal length.

Top module: `mesh_switchpoint`

## Requirements
- R1: While reset is high, the next clock edge leaves wave_o at 0, pref_o at the code 3'b111 (none), and conn_o and victim_o at 0.
- R2: In the search phase (phase_i = 1), a one on side i of wave_i (bit 0 = N, 1 = E, 2 = S, 3 = W) reaches every other side j of wave_o one cycle later if the connection between i and j is free (occ_i bit clear). It is never echoed back on side i. The connection index of each side pair is NE = 0, NS = 1, NW = 2, ES = 3, EW = 4, SW = 5.
- R3: Through an occupied connection that is not part of the current net, a search one appears cong_dly_i cycles later than it would through a free connection. This holds as long as the input stays high.
- R4: When no_cong_i is high, a search one is never passed through an occupied connection that is not part of the current net.
- R5: A connection marked in conn_o passes a search one with no added delay, even when it is occupied and no_cong_i is high.
- R6: In the search phase, while pref_o is none, the first cycle with any wave_i bit set loads pref_o with that side (0 = N to 3 = W). If several bits are set, the side chosen is the first set side found when stepping upward, with wrap-around, from side rnd_i. A loaded value holds until search_clr_i, which returns pref_o to none and clears wave_o in the next cycle.
- R7: A search pass started without search_clr_i keeps the preference already recorded, even when the wavefront now arrives on a different side.
- R8: In the allocate phase (phase_i = 2), a one on the lowest-indexed side i that differs from pref_o drives only side pref_o of wave_o one cycle later, and sets the conn_o bit for the pair (i, pref_o). A one arriving on the preferred side itself has no effect. conn_o bits only clear on net_clr_i.
- R9: A connection set by allocation whose occ_i bit is high in that cycle also sets its victim_o bit.
- R10: In the victim phase (phase_i = 3), a one on side i reaches side j one cycle later only if the victim_o bit of pair (i, j) is set.
- R11: In the idle phase (phase_i = 0), wave_o is 0 one cycle later. net_clr_i clears conn_o and victim_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 2 | 0 idle, 1 search, 2 allocate, 3 victim |
| search_clr_i | input | 1 | Clears the recorded side, the delay counters and wave_o |
| net_clr_i | input | 1 | Clears current-net connections and victim marks |
| no_cong_i | input | 1 | Blocks search through occupied connections |
| cong_dly_i | input | DLY_W | Extra cycles added by an occupied connection |
| wave_i | input | 4 | Wavefront arriving on N, E, S, W |
| occ_i | input | 6 | Connections held by other nets |
| rnd_i | input | 2 | Random start side for tie-breaking |
| wave_o | output | 4 | Registered wavefront leaving on N, E, S, W |
| pref_o | output | 3 | Recorded first-arrival side, 3'b111 when none |
| conn_o | output | 6 | Connections allocated to the current net |
| victim_o | output | 6 | Allocated connections that displaced another net |

## Verification
On every cycle, the assertions check the following: the reset state, that a recorded side is held until a clear, that a newly loaded side actually had a one arriving, that allocation drives at most one side, that conn_o bits only accumulate, that victims are always a subset of allocated connections, and that the idle phase is quiet. Some behaviours can only be shown by the bench's scenarios: the exact congestion latency, the blocking in no-congestion mode, the free pass over current-net connections, the random tie-break, the kept preference in a fallback pass, and victim-path propagation.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int NSIDE  = 4;
  localparam int SIDE_W = $clog2(NSIDE);
  localparam int NCONN  = NSIDE * (NSIDE - 1) / 2;
  localparam int PREF_W = SIDE_W + 1;
  localparam logic [PREF_W-1:0] PREF_NONE = '1;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SEARCH = 2'd1,
    PH_ALLOC  = 2'd2,
    PH_VICTIM = 2'd3
  } phase_e;

  // index of the connection joining two distinct sides
  function automatic int conn_of(input int a, input int b);
    int lo;
    int hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    return lo * (2 * NSIDE - lo - 1) / 2 + (hi - lo - 1);
  endfunction
endpackage

// File: rtl/sp_wave_fwd.sv
module sp_wave_fwd
  import sp_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_clr,
  input  logic             search_en,
  input  logic             no_cong,
  input  logic [DLY_W-1:0] dly,
  input  logic [NSIDE-1:0] arr,
  input  logic [NCONN-1:0] occ,
  input  logic [NCONN-1:0] cur,
  input  logic [NCONN-1:0] vic,
  output logic [NSIDE-1:0] srch_nxt,
  output logic [NSIDE-1:0] vic_nxt
);
  logic [NSIDE-1:0] free_req;
  logic [NSIDE-1:0] cong_req;

  always_comb begin
    free_req = '0;
    cong_req = '0;
    vic_nxt  = '0;
    for (int j = 0; j < NSIDE; j++) begin
      for (int i = 0; i < NSIDE; i++) begin
        if (i != j && arr[i]) begin
          if (cur[conn_of(i, j)] || !occ[conn_of(i, j)]) free_req[j] = 1'b1;
          else if (!no_cong) cong_req[j] = 1'b1;
          if (vic[conn_of(i, j)]) vic_nxt[j] = 1'b1;
        end
      end
    end
  end

  // one congestion-delay counter per leaving side
  for (genvar j = 0; j < NSIDE; j++) begin : g_side
    logic [DLY_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst || cnt_clr || !search_en || !cong_req[j]) cnt <= '0;
      else if (cnt != '1) cnt <= cnt + DLY_W'(1);
    end
    assign srch_nxt[j] = free_req[j] | (cong_req[j] & (cnt >= dly));
  end
endmodule

// File: rtl/sp_pref_rec.sv
module sp_pref_rec
  import sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              search_en,
  input  logic [NSIDE-1:0]  arr,
  input  logic [SIDE_W-1:0] rnd,
  output logic [PREF_W-1:0] pref
);
  logic [SIDE_W-1:0] pick;
  logic [SIDE_W-1:0] idx;

  // first set side at or after rnd, wrapping around
  always_comb begin
    pick = rnd;
    idx  = '0;
    for (int k = NSIDE - 1; k >= 0; k--) begin
      idx = rnd + SIDE_W'(k);
      if (arr[idx]) pick = idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) pref <= PREF_NONE;
    else if (search_en && pref == PREF_NONE && |arr) pref <= {1'b0, pick};
  end
endmodule

// File: rtl/sp_alloc.sv
module sp_alloc
  import sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              net_clr,
  input  logic              alloc_en,
  input  logic [NSIDE-1:0]  arr,
  input  logic [PREF_W-1:0] pref,
  input  logic [NCONN-1:0]  occ,
  output logic [NCONN-1:0]  conn,
  output logic [NCONN-1:0]  vic,
  output logic [NSIDE-1:0]  out_nxt
);
  logic [NCONN-1:0] set_mask;
  logic             hit;
  int               sel;
  int               psd;

  always_comb begin
    out_nxt  = '0;
    set_mask = '0;
    hit      = 1'b0;
    sel      = 0;
    psd      = int'(pref[SIDE_W-1:0]);
    if (pref != PREF_NONE) begin
      for (int i = NSIDE - 1; i >= 0; i--) begin
        if (arr[i] && i != psd) begin
          hit = 1'b1;
          sel = i;
        end
      end
      if (hit) begin
        out_nxt[psd]          = 1'b1;
        set_mask[conn_of(sel, psd)] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || net_clr) begin
      conn <= '0;
      vic  <= '0;
    end else if (alloc_en) begin
      conn <= conn | set_mask;
      vic  <= vic | (set_mask & occ);
    end
  end
endmodule

// File: rtl/mesh_switchpoint.sv
module mesh_switchpoint
  import sp_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        phase_i,
  input  logic              search_clr_i,
  input  logic              net_clr_i,
  input  logic              no_cong_i,
  input  logic [DLY_W-1:0]  cong_dly_i,
  input  logic [NSIDE-1:0]  wave_i,
  input  logic [NCONN-1:0]  occ_i,
  input  logic [SIDE_W-1:0] rnd_i,
  output logic [NSIDE-1:0]  wave_o,
  output logic [PREF_W-1:0] pref_o,
  output logic [NCONN-1:0]  conn_o,
  output logic [NCONN-1:0]  victim_o
);
  phase_e           ph;
  logic [NSIDE-1:0] srch_nxt;
  logic [NSIDE-1:0] vic_nxt;
  logic [NSIDE-1:0] alloc_nxt;

  assign ph = phase_e'(phase_i);

  sp_wave_fwd #(.DLY_W(DLY_W)) u_fwd (
    .clk      (clk),
    .rst      (rst),
    .cnt_clr  (search_clr_i),
    .search_en(ph == PH_SEARCH),
    .no_cong  (no_cong_i),
    .dly      (cong_dly_i),
    .arr      (wave_i),
    .occ      (occ_i),
    .cur      (conn_o),
    .vic      (victim_o),
    .srch_nxt (srch_nxt),
    .vic_nxt  (vic_nxt)
  );

  sp_pref_rec u_pref (
    .clk      (clk),
    .rst      (rst),
    .clr      (search_clr_i),
    .search_en(ph == PH_SEARCH),
    .arr      (wave_i),
    .rnd      (rnd_i),
    .pref     (pref_o)
  );

  sp_alloc u_alloc (
    .clk     (clk),
    .rst     (rst),
    .net_clr (net_clr_i),
    .alloc_en(ph == PH_ALLOC),
    .arr     (wave_i),
    .pref    (pref_o),
    .occ     (occ_i),
    .conn    (conn_o),
    .vic     (victim_o),
    .out_nxt (alloc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || search_clr_i) wave_o <= '0;
    else begin
      unique case (ph)
        PH_SEARCH: wave_o <= srch_nxt;
        PH_ALLOC:  wave_o <= alloc_nxt;
        PH_VICTIM: wave_o <= vic_nxt;
        default:   wave_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker
  import sp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [1:0]        phase_i,
  input logic              search_clr_i,
  input logic              net_clr_i,
  input logic [NSIDE-1:0]  wave_i,
  input logic [NSIDE-1:0]  wave_o,
  input logic [PREF_W-1:0] pref_o,
  input logic [NCONN-1:0]  conn_o,
  input logic [NCONN-1:0]  victim_o
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wave_o == '0 && pref_o == PREF_NONE && conn_o == '0 && victim_o == '0)); // R1

  AST_PREF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pref_o != PREF_NONE && !search_clr_i) |=> (pref_o == $past(pref_o))); // R6

  AST_PREF_FROM_ARRIVAL: assert property (@(posedge clk) disable iff (rst)
    (pref_o == PREF_NONE && !search_clr_i && phase_i == PH_SEARCH && wave_i != '0)
    |=> (pref_o != PREF_NONE && (($past(wave_i) >> pref_o[SIDE_W-1:0]) & 4'b0001) != 4'b0000)); // R6

  AST_ALLOC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_ALLOC) |=> $onehot0(wave_o)); // R8

  AST_CONN_KEEP: assert property (@(posedge clk) disable iff (rst)
    !net_clr_i |=> ((conn_o & $past(conn_o)) == $past(conn_o))); // R8

  AST_VICTIM_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (victim_o & ~conn_o) == '0); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_IDLE) |=> (wave_o == '0)); // R11
endmodule

bind mesh_switchpoint sp_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .phase_i     (phase_i),
  .search_clr_i(search_clr_i),
  .net_clr_i   (net_clr_i),
  .wave_i      (wave_i),
  .wave_o      (wave_o),
  .pref_o      (pref_o),
  .conn_o      (conn_o),
  .victim_o    (victim_o)
);

// File: tb/tb_mesh_switchpoint.sv
module tb_mesh_switchpoint;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_v = 1'b1;
  logic [1:0] phase_i = 2'd0;
  logic       search_clr_i = 1'b0;
  logic       net_clr_i = 1'b0;
  logic       no_cong_i = 1'b0;
  logic [3:0] cong_dly_i = 4'd3;
  logic [3:0] wave_i = '0;
  logic [5:0] occ_i = '0;
  logic [1:0] rnd_i = '0;
  logic [3:0] wave_o;
  logic [2:0] pref_o;
  logic [5:0] conn_o;
  logic [5:0] victim_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] out;
    logic [2:0] pref;
    logic [5:0] conn;
    logic [5:0] vic;
    string      req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  mesh_switchpoint #(.DLY_W(4)) dut (
    .clk(clk), .rst(rst), .phase_i(phase_i), .search_clr_i(search_clr_i),
    .net_clr_i(net_clr_i), .no_cong_i(no_cong_i), .cong_dly_i(cong_dly_i),
    .wave_i(wave_i), .occ_i(occ_i), .rnd_i(rnd_i), .wave_o(wave_o),
    .pref_o(pref_o), .conn_o(conn_o), .victim_o(victim_o)
  );

  localparam logic [1:0] ID = 2'd0, SR = 2'd1, AL = 2'd2, VC = 2'd3;

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic [1:0] ph, input logic [3:0] win, input logic [5:0] occ,
                      input logic nc, input logic sc, input logic nk, input logic [1:0] rn,
                      input logic [3:0] eo, input logic [2:0] ep, input logic [5:0] ec,
                      input logic [5:0] ev, input string rq);
    exp_t e;
    @(negedge clk);
    rst = rst_v; phase_i = ph; wave_i = win; occ_i = occ; no_cong_i = nc;
    search_clr_i = sc; net_clr_i = nk; rnd_i = rn;
    e.out = eo; e.pref = ep; e.conn = ec; e.vic = ev; e.req = rq;
    q.push_back(e);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (wave_o !== e.out || pref_o !== e.pref || conn_o !== e.conn || victim_o !== e.vic) begin
          failures++;
          $display("FAIL %s: got wave=%b pref=%b conn=%b vic=%b expected wave=%b pref=%b conn=%b vic=%b",
                   e.req, wave_o, pref_o, conn_o, victim_o, e.out, e.pref, e.conn, e.vic);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired before the scenario list ended (R1)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(ID, 4'b0000, 6'h00, 0, 0, 0, 2'd0, 4'b0000, 3'b111, 6'h00, 6'h00, "R1 reset");
    rst_v = 1'b0;
    step(SR, 4'b0000, 6'h00, 0, 1, 0, 2'd0, 4'b0000, 3'b111, 6'h00, 6'h00, "R6 clear");
    // R2 free forwarding from N
    step(SR, 4'b0001, 6'h00, 0, 0, 0, 2'd0, 4'b1110, 3'd0, 6'h00, 6'h00, "R2 free from N");
    step(SR, 4'b0011, 6'h00, 0, 0, 0, 2'd1, 4'b1111, 3'd0, 6'h00, 6'h00, "R6 hold");
    // R6 random tie-break
    step(SR, 4'b0000, 6'h00, 0, 1, 0, 2'd0, 4'b0000, 3'b111, 6'h00, 6'h00, "R6 clear");
    step(SR, 4'b1010, 6'h00, 0, 0, 0, 2'd2, 4'b1111, 3'd3, 6'h00, 6'h00, "R6 tie start S");
    step(SR, 4'b0000, 6'h00, 0, 1, 0, 2'd0, 4'b0000, 3'b111, 6'h00, 6'h00, "R6 clear");
    step(SR, 4'b1010, 6'h00, 0, 0, 0, 2'd0, 4'b1111, 3'd1, 6'h00, 6'h00, "R6 tie start N");
    // R3 congestion delay of 3
    step(SR, 4'b0000, 6'h00, 0, 1, 0, 2'd0, 4'b0000, 3'b111, 6'h00, 6'h00, "R6 clear");
    for (int k = 0; k < 3; k++)
      step(SR, 4'b0001, 6'h3F, 0, 0, 0, 2'd0, 4'b0000, 3'd0, 6'h00, 6'h00, "R3 delayed");
    step(SR, 4'b0001, 6'h3F, 0, 0, 0, 2'd0, 4'b1110, 3'd0, 6'h00, 6'h00, "R3 arrives");
    // R4 no-congestion mode
    step(SR, 4'b0000, 6'h00, 0, 1, 0, 2'd0, 4'b0000, 3'b111, 6'h00, 6'h00, "R6 clear");
    for (int k = 0; k < 5; k++)
      step(SR, 4'b0001, 6'h3F, 1, 0, 0, 2'd0, 4'b0000, 3'd0, 6'h00, 6'h00, "R4 blocked");
    // R8 / R9 allocation
    step(SR, 4'b0000, 6'h00, 0, 1, 0, 2'd0, 4'b0000, 3'b111, 6'h00, 6'h00, "R6 clear");
    step(SR, 4'b1000, 6'h00, 0, 0, 0, 2'd0, 4'b0111, 3'd3, 6'h00, 6'h00, "R2 free from W");
    step(AL, 4'b0010, 6'h00, 0, 0, 0, 2'd0, 4'b1000, 3'd3, 6'b010000, 6'h00, "R8 allocate EW");
    step(AL, 4'b0001, 6'b000100, 0, 0, 0, 2'd0, 4'b1000, 3'd3, 6'b010100, 6'b000100, "R9 victim NW");
    step(AL, 4'b1000, 6'h00, 0, 0, 0, 2'd0, 4'b0000, 3'd3, 6'b010100, 6'b000100, "R8 preferred side ignored");
    // R5 current-net connection is free
    step(SR, 4'b0000, 6'h00, 0, 1, 0, 2'd0, 4'b0000, 3'b111, 6'b010100, 6'b000100, "R6 clear");
    step(SR, 4'b0010, 6'h3F, 1, 0, 0, 2'd0, 4'b1000, 3'd1, 6'b010100, 6'b000100, "R5 own net passes");
    step(SR, 4'b0010, 6'h3F, 0, 0, 0, 2'd0, 4'b1000, 3'd1, 6'b010100, 6'b000100, "R5 no delay");
    // R10 victim propagation
    step(VC, 4'b0001, 6'h00, 0, 0, 0, 2'd0, 4'b1000, 3'd1, 6'b010100, 6'b000100, "R10 along victim");
    step(VC, 4'b0010, 6'h00, 0, 0, 0, 2'd0, 4'b0000, 3'd1, 6'b010100, 6'b000100, "R10 non-victim quiet");
    // R7 fallback pass keeps preference
    step(SR, 4'b0001, 6'h00, 0, 0, 0, 2'd0, 4'b1110, 3'd1, 6'b010100, 6'b000100, "R7 fallback keeps pref");
    // R11 idle and net clear
    step(ID, 4'b1111, 6'h00, 0, 0, 1, 2'd0, 4'b0000, 3'd1, 6'h00, 6'h00, "R11 net clear");
    step(ID, 4'b1111, 6'h00, 0, 0, 0, 2'd0, 4'b0000, 3'd1, 6'h00, 6'h00, "R11 idle quiet");
    step(ID, 4'b0000, 6'h00, 0, 0, 0, 2'd0, 4'b0000, 3'd1, 6'h00, 6'h00, "R11 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule